// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache with Content-Addressed Tags

This block is an 8 KB data cache that sits between an embedded processor's load/store unit and a slower word-wide memory. The data store has 256 lines of eight 32-bit words each. The lines are grouped into 8 sets of 32 ways. For each request, the tag store compares every way of the addressed set against the request tag in parallel. A way only takes part in that compare while its valid flag is set. The matching way then selects a word in a separate data array.

A hit finishes without touching memory. A load hit returns the word, and a store hit updates the cached word and marks the line dirty. Each line has two dirty flags, one for words 0-3 and one for words 4-7. On a miss, each set's own rotating pointer names the victim way. The cache writes back only the dirty halves of that line, then fetches the whole new line, and then repeats the lookup. Because the lookup is repeated, a store miss is merged into the freshly filled line (write-allocate).

The controller moves through five named states:
- ST_IDLE accepts a request and goes to ST_LOOKUP.
- ST_LOOKUP goes to ST_RESPOND on a hit. On a miss it goes to ST_WRITEBACK if the victim has a dirty half, and to ST_REFILL otherwise.
- ST_WRITEBACK streams a dirty half. It moves on to the upper half if that half is also dirty, and goes to ST_REFILL when done.
- ST_REFILL fetches eight words and returns to ST_LOOKUP.
- ST_RESPOND raises cpu_ready for one cycle and returns to ST_IDLE.

Top module: `cam_wb_cache`

## Requirements
- R1: After reset every line is invalid and both cpu_ready and mem_valid are low. The first access to any address is therefore a miss.
- R2: A load that hits returns the stored word with no memory beat, three clock edges after the request is first seen in ST_IDLE.
- R3: A store that hits changes only the cached word. No memory write occurs, and a later load of that address returns the stored value.
- R4: A line fill issues eight read beats with mem_we low, at the line base address and then each following word address in ascending order.
- R5: Every set has its own 5-bit victim pointer. The pointer is 0 after reset and advances by one on each allocation in that set only. A line therefore stays resident until 32 further allocations have taken place in its set.
- R6: On eviction, each dirty half is written as four ascending write beats (words 0-3 for the lower half, 4-7 for the upper half). When both halves are dirty the lower half goes first. A clean half, or a clean line, produces no write beat.
- R7: A store miss first fills the line with no write beat, then merges the store. A later load of that address hits with the stored value.
- R8: While mem_valid is high and mem_ready is low, mem_addr and mem_we hold their values into the next cycle.
- R9: cpu_ready is high for exactly one cycle per request and is low throughout miss handling.
- R10: Address bits [4:2] select the word, bits [7:5] select the set and bits [31:8] are the tag. At most one way of a set matches any tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Request present; held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write-beat data |
| mem_ready | input | 1 | Memory accepts or completes the beat |
| mem_rdata | input | 32 | Read-beat data, valid with mem_ready |

## Verification
The bench drives a line through its whole life in one set. It fills the line, writes one half and then makes 31 more allocations in that set. The line must still hit after those, and must be evicted by the 32nd. A pointer that skipped a way or was shared between sets would evict it too early or too late. A second line is made dirty in both halves by a store miss and then a store hit. Its eviction must show eight write beats in ascending order, lower half first. A design that always wrote whole lines, ignored the upper flag or inverted the order shows up in the beat log. Eviction of a clean line must produce no write, which catches a dirty flag that is not cleared on fill. Random traffic over 40 tags per set, with memory that stalls at random, then checks that every load matches the last stored value. This exposes lost write-backs, and refill words landing in the wrong slot.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } cstate_t;
endpackage

// File: rtl/cwb_tag_cam.sv
// Tag store with a parallel per-set compare, plus valid and per-half dirty flags.
module cwb_tag_cam #(
    parameter int TAG_W    = 24,
    parameter int SET_BITS = 3,
    parameter int WAY_BITS = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_BITS-1:0]        lk_set,
    input  logic [TAG_W-1:0]           lk_tag,
    output logic [(1<<WAY_BITS)-1:0]   hit_vec,
    output logic                       hit,
    output logic [WAY_BITS-1:0]        hit_way,
    input  logic [WAY_BITS-1:0]        vic_way,
    output logic [TAG_W-1:0]           vic_tag,
    output logic [1:0]                 vic_dirty,
    input  logic                       alloc_en,
    input  logic                       mark_en,
    input  logic [WAY_BITS-1:0]        mark_way,
    input  logic                       mark_half
);
    localparam int WAYS = 1 << WAY_BITS;
    localparam int NL   = WAYS << SET_BITS;
    localparam int IW   = SET_BITS + WAY_BITS;

    logic [TAG_W-1:0] tag_mem [NL];
    logic [NL-1:0]    valid_q, dlo_q, dhi_q;
    logic [IW-1:0]    vidx, midx;

    assign vidx = {lk_set, vic_way};
    assign midx = {lk_set, mark_way};

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        localparam logic [WAY_BITS-1:0] GW = WAY_BITS'(g);
        logic [IW-1:0] idx;
        assign idx        = {lk_set, GW};
        assign hit_vec[g] = valid_q[idx] && (tag_mem[idx] == lk_tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++)
            if (hit_vec[i]) hit_way = WAY_BITS'(i);
    end

    assign vic_tag   = tag_mem[vidx];
    assign vic_dirty = {dhi_q[vidx], dlo_q[vidx]} & {2{valid_q[vidx]}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dlo_q   <= '0;
            dhi_q   <= '0;
        end else begin
            if (alloc_en) begin
                valid_q[vidx] <= 1'b1;
                dlo_q[vidx]   <= 1'b0;
                dhi_q[vidx]   <= 1'b0;
            end
            if (mark_en) begin
                if (mark_half) dhi_q[midx] <= 1'b1;
                else           dlo_q[midx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) tag_mem[vidx] <= lk_tag;
    end
endmodule

// File: rtl/cwb_rr_ptr.sv
// One rotating victim pointer per set.
module cwb_rr_ptr #(
    parameter int SET_BITS = 3,
    parameter int WAY_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] set_sel,
    input  logic                adv,
    output logic [WAY_BITS-1:0] ptr
);
    localparam int SETS = 1 << SET_BITS;

    logic [WAY_BITS-1:0] ptr_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv) begin
            ptr_q[set_sel] <= ptr_q[set_sel] + 1'b1;
        end
    end

    assign ptr = ptr_q[set_sel];
endmodule

// File: rtl/cwb_line_ram.sv
// Data array: one write port, one asynchronous read port.
module cwb_line_ram #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [1<<IDX_W];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cam_wb_cache.sv
module cam_wb_cache #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int WORD_BITS = 3,
    parameter int SET_BITS  = 3,
    parameter int WAY_BITS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    import cwb_pkg::*;

    localparam int OFF_BITS  = 2;
    localparam int TAG_W     = ADDR_W - SET_BITS - WORD_BITS - OFF_BITS;
    localparam int HALF_BITS = WORD_BITS - 1;
    localparam int IDX_W     = SET_BITS + WAY_BITS + WORD_BITS;
    localparam int SET_LO    = OFF_BITS + WORD_BITS;
    localparam int TAG_LO    = SET_LO + SET_BITS;

    cstate_t                 state_q;
    logic                    req_we_q;
    logic [ADDR_W-1:0]       req_addr_q;
    logic [DATA_W-1:0]       req_wdata_q, rdata_q;
    logic [WORD_BITS-1:0]    beat_q;
    logic                    half_q;

    logic [SET_BITS-1:0]     req_set;
    logic [TAG_W-1:0]        req_tag;
    logic [WORD_BITS-1:0]    req_word;

    logic [(1<<WAY_BITS)-1:0] hit_vec;
    logic                    hit;
    logic [WAY_BITS-1:0]     hit_way, rr_ptr;
    logic [TAG_W-1:0]        vic_tag;
    logic [1:0]              vic_dirty;
    logic                    alloc_en, mark_en;
    logic                    ram_we;
    logic [IDX_W-1:0]        ram_waddr, ram_raddr;
    logic [DATA_W-1:0]       ram_wdata, ram_rdata;

    assign req_set  = req_addr_q[TAG_LO-1:SET_LO];
    assign req_tag  = req_addr_q[ADDR_W-1:TAG_LO];
    assign req_word = req_addr_q[SET_LO-1:OFF_BITS];

    cwb_tag_cam #(.TAG_W(TAG_W), .SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) u_cam (
        .clk(clk), .rst_n(rst_n),
        .lk_set(req_set), .lk_tag(req_tag),
        .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way),
        .vic_way(rr_ptr), .vic_tag(vic_tag), .vic_dirty(vic_dirty),
        .alloc_en(alloc_en),
        .mark_en(mark_en), .mark_way(hit_way), .mark_half(req_word[WORD_BITS-1])
    );

    cwb_rr_ptr #(.SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) u_rr (
        .clk(clk), .rst_n(rst_n), .set_sel(req_set), .adv(alloc_en), .ptr(rr_ptr)
    );

    cwb_line_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    // State register and request/beat bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
            beat_q      <= '0;
            half_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_we_q    <= cpu_we;
                        req_addr_q  <= cpu_addr;
                        req_wdata_q <= cpu_wdata;
                        state_q     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    beat_q <= '0;
                    if (hit) begin
                        if (!req_we_q) rdata_q <= ram_rdata;
                        state_q <= ST_RESPOND;
                    end else if (vic_dirty[0]) begin
                        half_q  <= 1'b0;
                        state_q <= ST_WRITEBACK;
                    end else if (vic_dirty[1]) begin
                        half_q  <= 1'b1;
                        state_q <= ST_WRITEBACK;
                    end else begin
                        state_q <= ST_REFILL;
                    end
                end
                ST_WRITEBACK: begin
                    if (mem_ready) begin
                        if (&beat_q[HALF_BITS-1:0]) begin
                            beat_q <= '0;
                            if (!half_q && vic_dirty[1]) half_q  <= 1'b1;
                            else                         state_q <= ST_REFILL;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                ST_REFILL: begin
                    if (mem_ready) begin
                        beat_q <= beat_q + 1'b1;
                        if (&beat_q) state_q <= ST_LOOKUP;
                    end
                end
                ST_RESPOND: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Output and array-control decode.
    always_comb begin
        cpu_ready = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        alloc_en  = 1'b0;
        mark_en   = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = {req_set, hit_way, req_word};
        ram_wdata = req_wdata_q;
        ram_raddr = {req_set, hit_way, req_word};
        unique case (state_q)
            ST_LOOKUP: begin
                if (hit && req_we_q) begin
                    ram_we  = 1'b1;
                    mark_en = 1'b1;
                end
            end
            ST_WRITEBACK: begin
                ram_raddr = {req_set, rr_ptr, half_q, beat_q[HALF_BITS-1:0]};
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vic_tag, req_set, half_q, beat_q[HALF_BITS-1:0], {OFF_BITS{1'b0}}};
                mem_wdata = ram_rdata;
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                mem_addr  = {req_tag, req_set, beat_q, {OFF_BITS{1'b0}}};
                ram_we    = mem_ready;
                ram_waddr = {req_set, rr_ptr, beat_q};
                ram_wdata = mem_rdata;
                alloc_en  = mem_ready && (&beat_q);
            end
            ST_RESPOND: cpu_ready = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
    parameter int ADDR_W   = 32,
    parameter int WAY_BITS = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cpu_ready,
    input logic                      mem_valid,
    input logic                      mem_ready,
    input logic                      mem_we,
    input logic [ADDR_W-1:0]         mem_addr,
    input cwb_pkg::cstate_t          state_q,
    input logic                      hit,
    input logic [(1<<WAY_BITS)-1:0]  hit_vec,
    input logic                      alloc_en,
    input logic [WAY_BITS-1:0]       rr_ptr
);
    import cwb_pkg::*;

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    p_ready_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && mem_valid));

    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_hit_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && hit) |=> !mem_valid);

    p_rr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> (rr_ptr == $past(rr_ptr) + 1'b1));
endmodule

bind cam_wb_cache cwb_checker #(.ADDR_W(ADDR_W), .WAY_BITS(WAY_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .state_q(state_q), .hit(hit), .hit_vec(hit_vec),
    .alloc_en(alloc_en), .rr_ptr(rr_ptr)
);

// File: tb/sim_cam_wb_cache.sv
module sim_cam_wb_cache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we, cpu_ready;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    cam_wb_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int total = 0;
    int bad   = 0;
    logic [31:0] mem_arr [logic [31:0]];
    logic [31:0] ref_arr [logic [31:0]];
    logic [31:0] log_addr [64];
    logic        log_we   [64];
    int          log_n = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [31:0] init_val(input logic [31:0] a);
        return a ^ 32'h3C5A_96E1;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        logic [31:0] t, s, w;
        t = tag; s = set; w = word;
        return {t[23:0], s[2:0], w[2:0], 2'b00};
    endfunction

    function automatic logic [31:0] exp_of(input logic [31:0] a);
        return ref_arr.exists(a) ? ref_arr[a] : init_val(a);
    endfunction

    // Memory model with pseudo-random stalls.
    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready <= mem_valid && (lfsr[1:0] != 2'b00);
        mem_rdata <= mem_arr.exists(mem_addr) ? mem_arr[mem_addr] : init_val(mem_addr);
    end

    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (log_n < 64) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
            end
            log_n = log_n + 1;
            if (mem_we) mem_arr[mem_addr] = mem_wdata;
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] wd, output logic [31:0] rd);
        int w;
        w = 0;
        @(negedge clk);
        log_n     = 0;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = wd;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
            w++;
            if (w > 5000) break;
        end
        rd      = cpu_rdata;
        cpu_req = 1'b0;
        if (we) ref_arr[a] = wd;
    endtask

    task automatic check_fill(input int tag, input int set, input int start, input string rq);
        for (int i = 0; i < 8; i++)
            check(log_addr[start+i] == mk(tag, set, i) && !log_we[start+i], rq,
                  log_addr[start+i], mk(tag, set, i));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog: actual=no completion expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd, a, wd;
        int seed_dummy;
        seed_dummy = $urandom(32'd17);
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (4) @(negedge clk);
        check(cpu_ready === 1'b0 && mem_valid === 1'b0, "R1 idle outputs in reset",
              {30'd0, cpu_ready, mem_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Line A in set 1: cold miss, fill order, hit, store hit.
        acc(0, mk(32'h1000, 1, 1), 0, rd);
        check(log_n == 8, "R1 cold access misses", log_n, 8);
        check_fill(32'h1000, 1, 0, "R4 R10 fill order");
        check(rd == init_val(mk(32'h1000, 1, 1)), "R4 fill data", rd, init_val(mk(32'h1000, 1, 1)));
        acc(0, mk(32'h1000, 1, 7), 0, rd);
        check(log_n == 0 && rd == init_val(mk(32'h1000, 1, 7)), "R2 read hit", rd, init_val(mk(32'h1000, 1, 7)));
        acc(1, mk(32'h1000, 1, 1), 32'hDEADBEEF, rd);
        check(log_n == 0, "R3 store hit no memory", log_n, 0);
        acc(0, mk(32'h1000, 1, 1), 0, rd);
        check(rd == 32'hDEADBEEF && log_n == 0, "R3 store visible", rd, 32'hDEADBEEF);

        // 31 more allocations in set 1: A must still be resident.
        for (int k = 1; k <= 31; k++) acc(0, mk(32'h2000 + k, 1, 0), 0, rd);
        acc(0, mk(32'h1000, 1, 0), 0, rd);
        check(log_n == 0, "R5 line kept after 31 allocations", log_n, 0);
        // 32nd allocation evicts A: lower half dirty only.
        acc(0, mk(32'h2000 + 32, 1, 0), 0, rd);
        check(log_n == 12, "R6 half writeback beat count", log_n, 12);
        for (int i = 0; i < 4; i++)
            check(log_we[i] && log_addr[i] == mk(32'h1000, 1, i), "R6 lower half write",
                  log_addr[i], mk(32'h1000, 1, i));
        check_fill(32'h2000 + 32, 1, 4, "R4 fill after writeback");
        check(mem_arr.exists(mk(32'h1000, 1, 1)) && mem_arr[mk(32'h1000, 1, 1)] == 32'hDEADBEEF,
              "R6 written value", mem_arr[mk(32'h1000, 1, 1)], 32'hDEADBEEF);
        // Next allocation evicts the clean way 1 line.
        acc(0, mk(32'h2000 + 33, 1, 0), 0, rd);
        check(log_n == 8, "R6 clean eviction no write", log_n, 8);
        acc(0, mk(32'h1000, 1, 1), 0, rd);
        check(rd == 32'hDEADBEEF, "R6 evicted data round trip", rd, 32'hDEADBEEF);

        // Line B in set 2: store miss, both halves dirty.
        acc(1, mk(32'h3000, 2, 2), 32'h1111_2222, rd);
        check(log_n == 8, "R7 store miss fill", log_n, 8);
        check_fill(32'h3000, 2, 0, "R7 fill before merge");
        acc(0, mk(32'h3000, 2, 2), 0, rd);
        check(rd == 32'h1111_2222 && log_n == 0, "R7 merged store", rd, 32'h1111_2222);
        acc(1, mk(32'h3000, 2, 6), 32'h3333_4444, rd);
        check(log_n == 0, "R3 upper half store hit", log_n, 0);
        for (int k = 1; k <= 31; k++) acc(0, mk(32'h4000 + k, 2, 3), 0, rd);
        acc(0, mk(32'h3000, 2, 6), 0, rd);
        check(log_n == 0 && rd == 32'h3333_4444, "R5 set pointer independent", rd, 32'h3333_4444);
        acc(0, mk(32'h4000 + 32, 2, 3), 0, rd);
        check(log_n == 16, "R6 both halves beat count", log_n, 16);
        for (int i = 0; i < 8; i++)
            check(log_we[i] && log_addr[i] == mk(32'h3000, 2, i), "R6 lower then upper order",
                  log_addr[i], mk(32'h3000, 2, i));
        check_fill(32'h4000 + 32, 2, 8, "R4 fill after full writeback");

        // Random traffic with capacity pressure.
        for (int i = 0; i < 400; i++) begin
            a = mk(32'h5000 + $urandom_range(0, 39), $urandom_range(0, 7), $urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1) begin
                wd = $urandom;
                acc(1, a, wd, rd);
            end else begin
                acc(0, a, 0, rd);
                check(rd == exp_of(a), "R2 R6 random load", rd, exp_of(a));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule